// File: doc/BRIEF.md
# Programmable FIR Filter with Double-Buffered Coefficients

This block is a direct-form FIR filter with a fixed number of taps. Its tap weights are loaded at run time through a small host port. The port carries a coefficient word, a tap address, a write enable and a commit strobe.

Host writes go into a staging bank of coefficient registers. A commit copies the whole staging bank into a shadow bank in one clock edge. The multiply-accumulate datapath reads only the shadow bank. A fresh coefficient set can therefore be written while samples keep streaming through the filter with the set currently in force. Filtering is never paused for a reload.

The datapath has one multiplier per tap and an adder tree. The filtered result is combinational on the current input sample. The result therefore appears in the same cycle as that sample, with no added sample latency. A sample-valid input gates the delay line. The result-valid output mirrors sample-valid.

Top module: `prog_fir`

## Requirements
- R1: When `coef_we` is high and `coef_addr` is below TAPS, `coef_data` is stored into the staging register at that address. Staging contents do not change the filter output until a commit.
- R2: When `coef_commit` is high, every shadow register is loaded from its staging register at that clock edge.
- R3: A sample presented in the commit cycle, or in any earlier cycle, is filtered with the previous shadow set. The first sample presented in the cycle after the commit uses the new set.
- R4: If `coef_we` and `coef_commit` are high in the same cycle, the committed set includes the word being written in that cycle.
- R5: A write whose address is TAPS or above leaves both banks unchanged. The address is one bit wider than the tap index, so with TAPS=8 the addresses 8 to 15 are out of range.
- R6: The delay line shifts only in cycles where `smp_vld` is high. `res_vld` equals `smp_vld` in the same cycle.
- R7: `res_data` is the exact signed sum over k of shadow[k]·x[n−k], where x[n] is the current sample. The output width is SW+CW+ceil(log2 TAPS) bits, so the sum cannot overflow, even with every operand at −2^(W−1).
- R8: While `rst_n` is low at a clock edge, the delay line, the staging bank and the shadow bank are all cleared to zero. After reset the output is zero for any input until a nonzero set is committed.
- R9: The output has zero latency: the current input sample contributes to `res_data` in the same cycle with weight shadow[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_data | input | CW | Signed coefficient word to write |
| coef_addr | input | ADDR_W | Tap index of the write (ceil(log2 TAPS)+1 bits) |
| coef_we | input | 1 | Write the coefficient word into the staging bank |
| coef_commit | input | 1 | Copy the staging bank into the shadow bank |
| smp_data | input | SW | Signed input sample |
| smp_vld | input | 1 | Input sample is valid |
| res_data | output | ACC_W | Signed full-precision filter output |
| res_vld | output | 1 | Output is valid |

## Verification
The bench compares every cycle against a behavioural convolution model, so the exact cycle of each coefficient switch is checked.

The main target is the switch itself. The bench commits a highpass set while samples flow. A design that let staging writes leak into the datapath, or that applied the commit one cycle early or late, would produce a mixed-coefficient result around the switch.

The bench also drives a write and a commit in the same cycle. A design without the write bypass would drop the last tap of the new set.

Further cases cover the following faults. Out-of-range writes that aliased onto a real tap would corrupt a coefficient. Stall cycles that shifted the delay line would misalign the samples. An all-minimum-value load would show a truncated accumulator as a wrong sign. A reset that left either bank populated would give a nonzero output after reset.

// File: rtl/prog_fir_pkg.sv
// Package: shared defaults and width helpers for the programmable FIR.
// Assumes: tap count of at least 2.
package prog_fir_pkg;
    localparam int DEF_TAPS = 8;
    localparam int DEF_SW   = 16;
    localparam int DEF_CW   = 16;

    // Accumulator width that holds the sum of TAPS full-precision products.
    function automatic int acc_width(input int taps, input int sw, input int cw);
        return sw + cw + $clog2(taps);
    endfunction
endpackage

// File: rtl/fir_coef_bank.sv
// Module: fir_coef_bank
// Holds the staging and shadow coefficient banks. Host writes land in staging.
// A commit copies all of staging (including a same-cycle write) into shadow.
// Assumes: wr_addr is wider than the tap index so that out-of-range addresses exist.
module fir_coef_bank #(
    parameter int TAPS = 8,
    parameter int CW   = 16,
    parameter int AW   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [CW-1:0]             wr_data,
    input  logic                      commit,
    output logic [TAPS-1:0][CW-1:0]   shadow
);
    localparam int IDX_W = $clog2(TAPS);

    logic [TAPS-1:0][CW-1:0] staging;
    logic [TAPS-1:0][CW-1:0] staging_nxt;
    logic                    addr_ok;

    // Address range check against the tap count.
    assign addr_ok = (wr_addr < AW'(TAPS));

    // Next staging contents: current bank with the accepted write merged in.
    always_comb begin
        staging_nxt = staging;
        if (wr_en && addr_ok) begin
            staging_nxt[wr_addr[IDX_W-1:0]] = wr_data;
        end
    end

    // Staging bank register.
    always_ff @(posedge clk) begin
        if (!rst_n) staging <= '0;
        else        staging <= staging_nxt;
    end

    // Shadow bank register, loaded atomically on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow <= '0;
        else if (commit) shadow <= staging_nxt;
    end

    AST_STAGING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(staging)); // R1
    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= AW'(TAPS))) |=> $stable(staging)); // R5
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(shadow)); // R3
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_en) |=> (shadow == staging)); // R2
endmodule

// File: rtl/fir_delay_line.sv
// Module: fir_delay_line
// Sample history for the direct-form structure. Slot 0 is the live input
// (no register); slots 1..TAPS-1 are the previous valid samples.
// Assumes: TAPS >= 2; the line moves only on valid samples.
module fir_delay_line #(
    parameter int TAPS = 8,
    parameter int SW   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SW-1:0]            smp,
    input  logic                     vld,
    output logic [TAPS-1:0][SW-1:0]  window
);
    logic [TAPS-2:0][SW-1:0] hist;

    // Live sample feeds the zero-latency slot.
    assign window[0] = smp;

    // First history stage captures the live sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist[0] <= '0;
        else if (vld) hist[0] <= smp;
    end

    genvar k;
    generate
        for (k = 1; k < TAPS - 1; k++) begin : g_stage
            // Each later stage takes its predecessor on a valid sample.
            always_ff @(posedge clk) begin
                if (!rst_n)   hist[k] <= '0;
                else if (vld) hist[k] <= hist[k-1];
            end
        end
        for (k = 1; k < TAPS; k++) begin : g_win
            assign window[k] = hist[k-1];
        end
    endgenerate

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(hist)); // R6
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> (hist[0] == $past(smp))); // R6
endmodule

// File: rtl/fir_mac_tree.sv
// Module: fir_mac_tree
// Fully parallel multiply-accumulate: one signed multiplier per tap and a
// sign-extended sum at full precision.
// Assumes: AW_ACC >= SW+CW+clog2(TAPS), so the sum cannot overflow.
module fir_mac_tree #(
    parameter int TAPS   = 8,
    parameter int SW     = 16,
    parameter int CW     = 16,
    parameter int AW_ACC = 35
) (
    input  logic [TAPS-1:0][SW-1:0] window,
    input  logic [TAPS-1:0][CW-1:0] coefs,
    output logic [AW_ACC-1:0]       sum
);
    localparam int PW = SW + CW;

    logic signed [PW-1:0] prod [TAPS];

    genvar k;
    generate
        for (k = 0; k < TAPS; k++) begin : g_mul
            assign prod[k] = $signed(window[k]) * $signed(coefs[k]);
        end
    endgenerate

    // Sign-extend every product and add them together.
    always_comb begin
        sum = '0;
        for (int i = 0; i < TAPS; i++) begin
            sum = sum + {{(AW_ACC-PW){prod[i][PW-1]}}, prod[i]};
        end
    end
endmodule

// File: rtl/prog_fir.sv
// Module: prog_fir (top)
// Programmable direct-form FIR filter. Coefficients are double-buffered:
// the host fills staging, a commit swaps the set into shadow, and the
// datapath uses shadow only. The output is combinational on the live sample.
// Assumes: TAPS >= 2; the address is one bit wider than the tap index.
module prog_fir #(
    parameter int TAPS   = prog_fir_pkg::DEF_TAPS,
    parameter int SW     = prog_fir_pkg::DEF_SW,
    parameter int CW     = prog_fir_pkg::DEF_CW,
    parameter int ADDR_W = $clog2(TAPS) + 1,
    parameter int ACC_W  = prog_fir_pkg::acc_width(TAPS, SW, CW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     coef_data,
    input  logic [ADDR_W-1:0] coef_addr,
    input  logic              coef_we,
    input  logic              coef_commit,
    input  logic [SW-1:0]     smp_data,
    input  logic              smp_vld,
    output logic [ACC_W-1:0]  res_data,
    output logic              res_vld
);
    logic [TAPS-1:0][CW-1:0] shadow;
    logic [TAPS-1:0][SW-1:0] window;

    fir_coef_bank #(.TAPS(TAPS), .CW(CW), .AW(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .commit  (coef_commit),
        .shadow  (shadow)
    );

    fir_delay_line #(.TAPS(TAPS), .SW(SW)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp    (smp_data),
        .vld    (smp_vld),
        .window (window)
    );

    fir_mac_tree #(.TAPS(TAPS), .SW(SW), .CW(CW), .AW_ACC(ACC_W)) u_mac (
        .window (window),
        .coefs  (shadow),
        .sum    (res_data)
    );

    // Output valid tracks the input valid with zero latency.
    assign res_vld = smp_vld;

    AST_SHADOW_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!coef_commit && !$past(coef_commit)) |-> $stable(shadow)); // R3
endmodule

// File: tb/prog_fir_test.sv
`timescale 1ns/1ps
module prog_fir_test;
    localparam int TAPS  = 8;
    localparam int ACC_W = 35;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [15:0]       coef_data = '0;
    logic [3:0]        coef_addr = '0;
    logic              coef_we = 0;
    logic              coef_commit = 0;
    logic [15:0]       smp_data = '0;
    logic              smp_vld = 0;
    logic [ACC_W-1:0]  res_data;
    logic              res_vld;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state
    longint stg [TAPS];
    longint shd [TAPS];
    longint hist [$];

    always #2.5 clk = ~clk;

    prog_fir uut (
        .clk(clk), .rst_n(rst_n), .coef_data(coef_data), .coef_addr(coef_addr),
        .coef_we(coef_we), .coef_commit(coef_commit), .smp_data(smp_data),
        .smp_vld(smp_vld), .res_data(res_data), .res_vld(res_vld)
    );

    task automatic step(input bit we, input int addr, input int data, input bit cm,
                        input bit v, input int x, input string tag);
        longint expv;
        longint got;
        coef_we = we; coef_addr = 4'(addr); coef_data = 16'(data);
        coef_commit = cm; smp_vld = v; smp_data = 16'(x);
        #1;
        checks++;
        if (res_vld !== v) begin
            errors++;
            $display("FAIL %s: res_vld=%0b expected %0b", tag, res_vld, v);
        end
        if (v) begin
            expv = shd[0] * longint'(x);
            for (int k = 1; k < TAPS; k++) expv += shd[k] * hist[k-1];
            got = longint'($signed(res_data));
            checks++;
            if (got != expv) begin
                errors++;
                $display("FAIL %s: res_data=%0d expected %0d", tag, got, expv);
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin stg[k] = 0; shd[k] = 0; hist[k % (TAPS-1)] = 0; end
        end else begin
            if (we && addr < TAPS) stg[addr] = longint'($signed(16'(data)));
            if (cm) for (int k = 0; k < TAPS; k++) shd[k] = stg[k];
            if (v) begin
                hist.push_front(longint'($signed(16'(x))));
                void'(hist.pop_back());
            end
        end
        @(negedge clk);
    endtask

    function automatic int stim(input int i);
        return ((i * i * 37 + i * 11) % 2001) - 1000;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lp [TAPS] = '{120, 360, 720, 960, 960, 720, 360, 120};
        int hp [TAPS] = '{-90, 270, -600, 1100, -1100, 600, -270, 90};
        for (int k = 0; k < TAPS; k++) begin stg[k] = 0; shd[k] = 0; end
        for (int k = 0; k < TAPS - 1; k++) hist.push_back(0);
        @(negedge clk);
        // R8: reset held
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 777, "R8");
        rst_n = 1;
        step(0, 0, 0, 0, 1, 1234, "R8");
        // R1: load lowpass into staging while samples flow; output stays zero
        for (int k = 0; k < TAPS; k++) step(1, k, lp[k], 0, 1, stim(k), "R1");
        // R2: commit
        step(0, 0, 0, 1, 1, stim(50), "R2");
        // R9 / R6: filter with stall gaps
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, (i % 5) != 3, stim(i + 60), "R6");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, (i == 2) ? 5000 : 0, "R9");
        // R3: load highpass while filtering; last write shares the commit cycle (R4)
        for (int k = 0; k < TAPS - 1; k++) step(1, k, hp[k], 0, 1, stim(k + 200), "R3");
        step(1, TAPS - 1, hp[TAPS-1], 1, 1, stim(300), "R4");
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, stim(i + 310), "R4");
        // R5: out-of-range writes then commit
        for (int a = TAPS; a < 16; a++) step(1, a, 32767, 0, 1, stim(a + 400), "R5");
        step(0, 0, 0, 1, 1, stim(420), "R5");
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, stim(i + 430), "R5");
        // R7: extreme operands
        for (int k = 0; k < TAPS; k++) step(1, k, -32768, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 0, 0, "R7");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, -32768, "R7");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, (i % 2) ? 32767 : -32768, "R7");
        // R8: reset mid-stream clears both banks and history
        rst_n = 0;
        step(0, 0, 0, 0, 1, 999, "R8");
        rst_n = 1;
        step(0, 0, 0, 1, 1, 4321, "R8");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, stim(i + 500), "R8");
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule